// File: doc/BRIEF.md
# Keyboard and Mouse Host Mailbox

This block is the controller-side half of a legacy keyboard-controller host channel. The host sees two byte ports. The data port returns the pending output byte when read and accepts a byte when written. The command/status port returns a status byte when read and accepts a command byte when written. The firmware sees four small registers. Two write-only data-out registers, one for keyboard traffic and one for auxiliary (mouse) traffic, load the same single output byte. The register that was written decides which of the two host interrupt lines is raised for that byte.

In the other direction, any host write stores one input byte and marks the input buffer full. The firmware drains it through a read-only data-in register. Two level interrupts tell the firmware that the input buffer holds a byte, or that the host has taken the output byte. A control register holds all four interrupt enables.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the output-full flag, input-full flag, auxiliary-source flag, command flag, pending output-empty event, every interrupt output and every enable bit are 0, so both host ports and the firmware control and status reads return 0.
- R2: A firmware write to register 1 (keyboard data-out) loads the output byte, sets the output-full flag (status bit 0) and clears the auxiliary flag (status bit 5) on the next clock. While the byte is pending, `hostKbdIrq` equals control bit 0.
- R3: A firmware write to register 2 (mouse data-out) loads the same output byte, sets the output-full flag and sets the auxiliary flag. While the byte is pending, `hostAuxIrq` equals control bit 1 and `hostKbdIrq` stays low.
- R4: A host read of the data port while output-full is set records an output-empty event. `fwObeIrq` is that event ANDed with control bit 2. A firmware write to either data-out register clears the event, so `fwObeIrq` is low on the next clock.
- R5: A host read of the data port (`hostCmd`=0) returns the output byte. If output-full was set, the read clears it, which drops both host interrupts on the next clock. If output-full was clear, the read changes nothing. A host read of the command port returns the status byte and has no side effect.
- R6: A host write to either port stores the byte and sets the input-full flag (status bit 1). It sets the command flag (status bit 3) to 1 for the command port and to 0 for the data port. `fwIbfIrq` equals input-full ANDed with control bit 3.
- R7: A firmware read of register 3 returns the stored input byte and clears input-full, so `fwIbfIrq` is low on the next clock.
- R8: A firmware data-out write in the same cycle as a host data-port read wins: output-full ends set, holding the new byte. A host write in the same cycle as a firmware data-in read wins: input-full stays set, holding the new byte, and the firmware read returns the old byte.
- R9: Firmware register 0 holds the four enables in bits 3:0 (bit 0 keyboard host, bit 1 mouse host, bit 2 output-empty, bit 3 input-full) and reads back the same value. Firmware register 1 reads the status byte, and register 2 reads 0. A cleared enable holds its interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostCmd | input | 1 | Host port select: 1 command/status, 0 data |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte (output byte or status) |
| fwWrEn | input | 1 | Firmware write strobe |
| fwRdEn | input | 1 | Firmware read strobe |
| fwAddr | input | 2 | Firmware register select |
| fwWrData | input | 8 | Firmware write byte |
| fwRdData | output | 8 | Firmware read byte |
| hostKbdIrq | output | 1 | Host keyboard interrupt |
| hostAuxIrq | output | 1 | Host mouse interrupt |
| fwObeIrq | output | 1 | Firmware output-empty interrupt |
| fwIbfIrq | output | 1 | Firmware input-full interrupt |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. In the first, a firmware data-out write lands on the cycle the host drains the output byte. In the second, a host write lands on the cycle the firmware drains the input byte. Either order of the outcome looks plausible on its own. Directed steps force both collisions with the buffer already full, and with the source switching from keyboard to mouse. Several thousand random cycles then run all strobes, addresses and enable patterns against a bench reference model, so the collisions also recur with every enable combination.

// File: rtl/kbc_mbox_pkg.sv
package kbc_mbox_pkg;
  localparam int FW_ADDR_W = 2;

  typedef enum logic [FW_ADDR_W-1:0] {
    FW_CTRL     = 2'd0,
    FW_KBD_OUT  = 2'd1,
    FW_AUX_OUT  = 2'd2,
    FW_DATA_IN  = 2'd3
  } fw_reg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOut;
    logic loadIn;
    logic loadCtrl;
  } strobe_t;

  typedef struct packed {
    logic obf;
    logic ibf;
    logic aux;
    logic cmd;
    logic obe;
  } flags_t;

  // bit order matches firmware control register bits 3..0
  typedef struct packed {
    logic ibfIrqEn;
    logic obeIrqEn;
    logic auxIrqEn;
    logic kbdIrqEn;
  } ctrl_t;
endpackage

// File: rtl/kbc_mbox_ctrl.sv
module kbc_mbox_ctrl
  import kbc_mbox_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostWrEn,
  input  logic    hostRdEn,
  input  logic    hostCmd,
  input  logic    fwWrEn,
  input  logic    fwRdEn,
  input  fw_reg_e fwReg,
  input  ctrl_t   ctrlReg,
  output strobe_t strobe,
  output flags_t  flags,
  output logic    hostKbdIrq,
  output logic    hostAuxIrq,
  output logic    fwObeIrq,
  output logic    fwIbfIrq
);
  logic fwOutWr, fwAuxWr, hostDrain, fwInRd;
  flags_t flagsNxt;

  always_comb begin
    fwAuxWr   = fwWrEn && (fwReg == FW_AUX_OUT);
    fwOutWr   = fwWrEn && ((fwReg == FW_KBD_OUT) || fwAuxWr);
    hostDrain = hostRdEn && !hostCmd && flags.obf;
    fwInRd    = fwRdEn && (fwReg == FW_DATA_IN);

    strobe.loadOut  = fwOutWr;
    strobe.loadIn   = hostWrEn;
    strobe.loadCtrl = fwWrEn && (fwReg == FW_CTRL);

    flagsNxt = flags;
    // firmware load takes priority over a host drain in the same cycle
    if (fwOutWr) begin
      flagsNxt.obf = 1'b1;
      flagsNxt.aux = fwAuxWr;
      flagsNxt.obe = 1'b0;
    end else if (hostDrain) begin
      flagsNxt.obf = 1'b0;
      flagsNxt.obe = 1'b1;
    end
    // host load takes priority over a firmware drain in the same cycle
    if (hostWrEn) begin
      flagsNxt.ibf = 1'b1;
      flagsNxt.cmd = hostCmd;
    end else if (fwInRd) begin
      flagsNxt.ibf = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= flagsNxt;
  end

  always_comb begin
    hostKbdIrq = flags.obf && !flags.aux && ctrlReg.kbdIrqEn;
    hostAuxIrq = flags.obf &&  flags.aux && ctrlReg.auxIrqEn;
    fwObeIrq   = flags.obe && ctrlReg.obeIrqEn;
    fwIbfIrq   = flags.ibf && ctrlReg.ibfIrqEn;
  end
endmodule

// File: rtl/kbc_mbox_dp.sv
module kbc_mbox_dp
  import kbc_mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  flags_t            flags,
  input  logic              hostCmd,
  input  fw_reg_e           fwReg,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] fwWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] fwRdData,
  output ctrl_t             ctrlReg
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [DATA_W-1:0] outByte, inByte, statusByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outByte <= '0;
      inByte  <= '0;
      ctrlReg <= '0;
    end else begin
      if (strobe.loadOut)  outByte <= fwWrData;
      if (strobe.loadIn)   inByte  <= hostWrData;
      if (strobe.loadCtrl) ctrlReg <= ctrl_t'(fwWrData[CTRL_W-1:0]);
    end
  end

  always_comb begin
    statusByte    = '0;
    statusByte[0] = flags.obf;
    statusByte[1] = flags.ibf;
    statusByte[3] = flags.cmd;
    statusByte[5] = flags.aux;
    hostRdData = hostCmd ? statusByte : outByte;
    case (fwReg)
      FW_CTRL:    fwRdData = DATA_W'(ctrlReg);
      FW_KBD_OUT: fwRdData = statusByte;
      FW_AUX_OUT: fwRdData = '0;
      default:    fwRdData = inByte;
    endcase
  end
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  input  logic       hostCmd,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  input  logic       fwWrEn,
  input  logic       fwRdEn,
  input  logic [1:0] fwAddr,
  input  logic [7:0] fwWrData,
  output logic [7:0] fwRdData,
  output logic       hostKbdIrq,
  output logic       hostAuxIrq,
  output logic       fwObeIrq,
  output logic       fwIbfIrq
);
  strobe_t strobe;
  flags_t  flags;
  ctrl_t   ctrlReg;
  fw_reg_e fwReg;
  logic    obfFlag, ibfFlag;

  assign fwReg   = fw_reg_e'(fwAddr);
  assign obfFlag = flags.obf;
  assign ibfFlag = flags.ibf;

  kbc_mbox_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostCmd(hostCmd), .fwWrEn(fwWrEn), .fwRdEn(fwRdEn), .fwReg(fwReg),
    .ctrlReg(ctrlReg), .strobe(strobe), .flags(flags),
    .hostKbdIrq(hostKbdIrq), .hostAuxIrq(hostAuxIrq),
    .fwObeIrq(fwObeIrq), .fwIbfIrq(fwIbfIrq)
  );

  kbc_mbox_dp #(.DATA_W(8)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flags(flags),
    .hostCmd(hostCmd), .fwReg(fwReg), .hostWrData(hostWrData),
    .fwWrData(fwWrData), .hostRdData(hostRdData), .fwRdData(fwRdData),
    .ctrlReg(ctrlReg)
  );
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostWrEn,
  input logic       hostRdEn,
  input logic       hostCmd,
  input logic       fwWrEn,
  input logic       fwRdEn,
  input logic [1:0] fwAddr,
  input logic       obfFlag,
  input logic       ibfFlag,
  input logic       hostKbdIrq,
  input logic       hostAuxIrq,
  input logic       fwObeIrq,
  input logic       fwIbfIrq
);
  logic fwOutWr;
  assign fwOutWr = fwWrEn && (fwAddr == 2'd1 || fwAddr == 2'd2);

  AST_KBD_LOAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    fwWrEn && fwAddr == 2'd1 |=> obfFlag && !hostAuxIrq); // R2
  AST_AUX_LOAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    fwWrEn && fwAddr == 2'd2 |=> obfFlag && !hostKbdIrq); // R3
  AST_OBE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    fwOutWr |=> !fwObeIrq); // R4
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    hostRdEn && !hostCmd && obfFlag && !fwOutWr |=> !obfFlag && !hostKbdIrq && !hostAuxIrq); // R5
  AST_HOST_WR_FULL: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |=> ibfFlag); // R6
  AST_FW_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    fwRdEn && fwAddr == 2'd3 && !hostWrEn |=> !ibfFlag && !fwIbfIrq); // R7
  AST_ONE_HOST_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hostKbdIrq, hostAuxIrq})); // R3
endmodule

bind kbc_mailbox kbc_mailbox_chk i_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .hostCmd(hostCmd), .fwWrEn(fwWrEn), .fwRdEn(fwRdEn), .fwAddr(fwAddr),
  .obfFlag(obfFlag), .ibfFlag(ibfFlag), .hostKbdIrq(hostKbdIrq),
  .hostAuxIrq(hostAuxIrq), .fwObeIrq(fwObeIrq), .fwIbfIrq(fwIbfIrq)
);

// File: tb/test_kbc_mailbox.sv
module test_kbc_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic clk = 0, rstN = 0;
  logic hostWrEn = 0, hostRdEn = 0, hostCmd = 0, fwWrEn = 0, fwRdEn = 0;
  logic [7:0] hostWrData = 0, fwWrData = 0;
  logic [1:0] fwAddr = 0;
  logic [7:0] hostRdData, fwRdData;
  logic hostKbdIrq, hostAuxIrq, fwObeIrq, fwIbfIrq;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit mObf, mIbf, mAux, mCmd, mObe;
  logic [7:0] mOut, mIn;
  logic [3:0] mCtrl;

  kbc_mailbox i_kbc_mailbox (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] statusExp();
    return {2'b0, mAux, 1'b0, mCmd, 1'b0, mIbf, mObf};
  endfunction

  function automatic logic [7:0] fwRdExp(logic [1:0] a);
    case (a)
      2'd0: return {4'b0, mCtrl};
      2'd1: return statusExp();
      2'd2: return 8'h00;
      default: return mIn;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mObf = 0; mIbf = 0; mAux = 0; mCmd = 0; mObe = 0;
    mOut = 0; mIn = 0; mCtrl = 0;
  endtask

  task automatic modelStep();
    bit fwOut, drain, fwIn;
    fwOut = fwWrEn && (fwAddr == 2'd1 || fwAddr == 2'd2);
    drain = hostRdEn && !hostCmd && mObf;
    fwIn  = fwRdEn && fwAddr == 2'd3;
    if (fwOut) begin
      mObf = 1; mAux = (fwAddr == 2'd2); mOut = fwWrData; mObe = 0;
    end else if (drain) begin
      mObf = 0; mObe = 1;
    end
    if (fwWrEn && fwAddr == 2'd0) mCtrl = fwWrData[3:0];
    if (hostWrEn) begin
      mIbf = 1; mIn = hostWrData; mCmd = hostCmd;
    end else if (fwIn) mIbf = 0;
  endtask

  task automatic checkIrqs();
    check("R2 hostKbdIrq", 8'(hostKbdIrq), 8'(mObf && !mAux && mCtrl[0]));
    check("R3 hostAuxIrq", 8'(hostAuxIrq), 8'(mObf && mAux && mCtrl[1]));
    check("R4 fwObeIrq",   8'(fwObeIrq),   8'(mObe && mCtrl[2]));
    check("R6 fwIbfIrq",   8'(fwIbfIrq),   8'(mIbf && mCtrl[3]));
  endtask

  // inputs set just after a falling edge; reads checked there, state after rise
  task automatic cycle(bit hw, bit hr, bit hc, logic [7:0] hd,
                       bit fw, bit fr, logic [1:0] fa, logic [7:0] fd);
    @(negedge clk);
    hostWrEn = hw; hostRdEn = hr; hostCmd = hc; hostWrData = hd;
    fwWrEn = fw; fwRdEn = fr; fwAddr = fa; fwWrData = fd;
    #1;
    check(hc ? "R5 host status read" : "R5 host data read", hostRdData,
          hc ? statusExp() : mOut);
    check("R7 R9 fw read", fwRdData, fwRdExp(fa));
    @(posedge clk);
    modelStep();
    #1;
    hostWrEn = 0; hostRdEn = 0; fwWrEn = 0; fwRdEn = 0;
    checkIrqs();
  endtask

  task automatic peekStatus(string tag, logic [7:0] exp);
    @(negedge clk);
    hostCmd = 1; #1;
    check(tag, hostRdData, exp);
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    peekStatus("R1 status after reset", 8'h00);
    fwAddr = 2'd0; #1 check("R1 ctrl after reset", fwRdData, 8'h00);
    check("R1 irqs after reset", 8'({hostKbdIrq, hostAuxIrq, fwObeIrq, fwIbfIrq}), 8'h00);

    // R9 enable all, read back
    cycle(0,0,0,0, 1,0,2'd0,8'hFF);
    cycle(0,0,0,0, 0,1,2'd0,0);
    // R2 keyboard load
    cycle(0,0,0,0, 1,0,2'd1,8'h5A);
    peekStatus("R2 status kbd", 8'h01);
    check("R2 kbd irq high", 8'(hostKbdIrq), 8'h01);
    // R3 mouse load replaces source
    cycle(0,0,0,0, 1,0,2'd2,8'hC3);
    peekStatus("R3 status aux", 8'h21);
    check("R3 aux irq only", 8'({hostKbdIrq, hostAuxIrq}), 8'h01);
    // R5 drain, R4 obe
    cycle(0,1,0,0, 0,0,2'd3,0);
    check("R4 obe irq after drain", 8'(fwObeIrq), 8'h01);
    cycle(0,1,0,0, 0,0,2'd3,0);   // R5 read while empty: no change
    // R8 collision: fw write wins over host drain
    cycle(0,0,0,0, 1,0,2'd1,8'h11);
    cycle(0,1,0,0, 1,0,2'd2,8'h22);
    peekStatus("R8 fw write wins", 8'h21);
    // R6 host command write then R8 host write beats fw drain
    cycle(1,0,1,8'hAB, 0,0,2'd0,0);
    peekStatus("R6 cmd flag", 8'h2B);
    cycle(1,0,0,8'hCD, 0,1,2'd3,0);
    check("R8 ibf kept", 8'(fwIbfIrq), 8'h01);
    cycle(0,0,0,0, 0,1,2'd3,0);   // R7 drains 0xCD
    check("R7 ibf irq low", 8'(fwIbfIrq), 8'h00);
    // R9 disabled enables hold irqs low
    cycle(0,0,0,0, 1,0,2'd0,8'h00);
    cycle(1,0,0,8'h01, 1,0,2'd1,8'h02);
    check("R9 irqs masked", 8'({hostKbdIrq, hostAuxIrq, fwObeIrq, fwIbfIrq}), 8'h00);

    // constrained random
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < RAND_CYCLES; i++) begin
      cycle($urandom_range(5) == 0, $urandom_range(3) == 0, $urandom_range(1),
            8'($urandom), $urandom_range(4) == 0, $urandom_range(3) == 0,
            2'($urandom_range(3)), 8'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000 - 1000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule